// File: doc/BRIEF.md
# Control-Transfer Next-PC Unit

This block owns the program counter of a simple 32-bit in-order core and decides where it goes after each control-transfer instruction. Each cycle with `instr_valid` high, it takes one already-decoded instruction as an operation code, the two source register values, a sign-extended immediate and the destination register index. It produces the next PC, a link-register write, and a run state. The run state is either running, stopped on a misaligned target with a cause code, or halted because an instruction jumped or branched to its own address.

The target of a direct jump or of a conditional branch is the current PC plus the immediate. The target of a register-indirect jump is the first operand plus the immediate, with bit 0 cleared. The block checks alignment and the self-target condition before it looks at the branch condition, so a badly formed branch stops the core whatever its operands are. A trap or a halt is sticky: the PC freezes and no further instruction has any effect until reset. Instructions that transfer no control simply advance the PC by 4.

The operation code is 4 bits wide: 1 is the direct jump, 2 is the register-indirect jump, 8 is branch-if-equal, 9 is branch-if-not-equal, 12 is signed less-than, 13 is signed greater-or-equal, 14 is unsigned less-than and 15 is unsigned greater-or-equal. Every other value is a non-control instruction.

Top module: `nextpc_unit`

## Requirements
- R1: While `rst_n` is low, and after its release, `pc` equals the parameter RESET_PC (default 0x100), `trap_cause` is 0 and `halted` is 0.
- R2: A valid non-control code (0, 3 to 7, 10, 11) gives `next_pc` = `pc`+4 and `link_we` low, and `pc` takes that value at the clock edge.
- R3: A valid direct jump (code 1) whose target `pc`+`imm` is a multiple of 4 and differs from `pc` gives `next_pc` = target, `link_data` = `pc`+4 and `link_we` high.
- R4: A valid register-indirect jump (code 2) has the target (`rs1_val`+`imm`) with bit 0 cleared, and is otherwise handled as in R3.
- R5: `link_we` is never high when `rd_idx` is 0.
- R6: Codes 8, 9, 12 and 13 compare the operands as signed values for equal, not-equal, less-than and greater-or-equal. A taken branch loads `pc`+`imm`, a branch that is not taken loads `pc`+4, and `link_we` stays low.
- R7: Codes 14 and 15 compare the operands as unsigned 32-bit values for less-than and greater-or-equal, and are otherwise handled as in R6.
- R8: A jump (code 1 or 2) whose target has bit 1 or bit 0 set keeps `next_pc` = `pc` and `link_we` low, and latches `trap_cause` = 1 at the clock edge.
- R9: A branch whose target `pc`+`imm` is not a multiple of 4 latches `trap_cause` = 2 and keeps the PC, even when the condition is false.
- R10: A jump or branch whose aligned target equals `pc` keeps `next_pc` = `pc` and `link_we` low, and sets `halted` at the clock edge.
- R11: Once `trap_cause` is nonzero or `halted` is 1, both hold their values, `pc` stays frozen and `link_we` stays low until reset.
- R12: When `instr_valid` is low, `pc` holds its value and `link_we` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_valid | input | 1 | An instruction is presented this cycle |
| op | input | 4 | Operation code |
| rd_idx | input | 5 | Link destination register index |
| rs1_val | input | 32 | First operand |
| rs2_val | input | 32 | Second operand |
| imm | input | 32 | Sign-extended immediate |
| pc | output | 32 | Current program counter |
| next_pc | output | 32 | PC value to load at the next edge |
| link_we | output | 1 | Link register write enable |
| link_data | output | 32 | Return address, pc+4 |
| trap_cause | output | 2 | 0 none, 1 misaligned jump, 2 misaligned branch |
| halted | output | 1 | Self-target halt latched |

## Verification
A wrong target adder or a wrong compare appears on `next_pc` in the same cycle the instruction is presented, and on `pc` one edge later. A run state that latches wrongly shows up on `trap_cause` or `halted` right after that edge. A run state that fails to hold shows up as `pc` moving or `link_we` rising on the next valid instruction. Each scenario therefore starts from a known reset PC, so that every difference is visible within two cycles.

// File: rtl/nextpc_unit.sv
module nextpc_unit #(
  parameter logic [31:0] RESET_PC = 32'h0000_0100
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        instr_valid,
  input  logic [3:0]  op,
  input  logic [4:0]  rd_idx,
  input  logic [31:0] rs1_val,
  input  logic [31:0] rs2_val,
  input  logic [31:0] imm,
  output logic [31:0] pc,
  output logic [31:0] next_pc,
  output logic        link_we,
  output logic [31:0] link_data,
  output logic [1:0]  trap_cause,
  output logic        halted
);
  localparam logic [3:0] OP_JMP  = 4'd1;
  localparam logic [3:0] OP_JMPR = 4'd2;
  localparam logic [1:0] CAUSE_JUMP   = 2'd1;
  localparam logic [1:0] CAUSE_BRANCH = 2'd2;

  logic        is_jmp, is_jmpr, is_br, is_ctrl;
  logic [31:0] sum, target, seq_pc;
  logic        misalign, self_hit, taken, stopped, fire;

  assign is_jmp  = (op == OP_JMP);
  assign is_jmpr = (op == OP_JMPR);
  assign is_br   = op[3] && (op[2:1] != 2'b01);
  assign is_ctrl = is_jmp || is_jmpr || is_br;

  assign sum      = (is_jmpr ? rs1_val : pc) + imm;
  assign target   = is_jmpr ? {sum[31:1], 1'b0} : sum;
  assign seq_pc   = pc + 32'd4;
  assign misalign = is_ctrl && (target[1:0] != 2'b00);
  assign self_hit = is_ctrl && !misalign && (target == pc);
  assign stopped  = halted || (trap_cause != 2'd0);
  assign fire     = instr_valid && !stopped;

  always_comb begin
    case (op[2:0])
      3'd0:    taken = (rs1_val == rs2_val);
      3'd1:    taken = (rs1_val != rs2_val);
      3'd4:    taken = ($signed(rs1_val) <  $signed(rs2_val));
      3'd5:    taken = ($signed(rs1_val) >= $signed(rs2_val));
      3'd6:    taken = (rs1_val <  rs2_val);
      3'd7:    taken = (rs1_val >= rs2_val);
      default: taken = 1'b0;
    endcase
  end

  always_comb begin
    if (!fire || misalign || self_hit)  next_pc = pc;
    else if (is_jmp || is_jmpr)         next_pc = target;
    else if (is_br && taken)            next_pc = target;
    else                                next_pc = seq_pc;
  end

  assign link_we   = fire && (is_jmp || is_jmpr) && !misalign && !self_hit && (rd_idx != 5'd0);
  assign link_data = seq_pc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc         <= RESET_PC;
      trap_cause <= 2'd0;
      halted     <= 1'b0;
    end else begin
      pc <= next_pc;
      if (fire && misalign) trap_cause <= is_br ? CAUSE_BRANCH : CAUSE_JUMP;
      if (fire && self_hit) halted <= 1'b1;
    end
  end
endmodule

// File: rtl/nextpc_unit_chk.sv
module nextpc_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        instr_valid,
  input logic [4:0]  rd_idx,
  input logic [31:0] pc,
  input logic        link_we,
  input logic [1:0]  trap_cause,
  input logic        halted
);
  a_r5_no_x0_link: assert property (@(posedge clk) disable iff (!rst_n)
    link_we |-> (rd_idx != 5'd0));

  a_r8_stop_no_link: assert property (@(posedge clk) disable iff (!rst_n)
    (halted || trap_cause != 2'd0) |-> !link_we);

  a_r11_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (halted || trap_cause != 2'd0) |=> ($stable(pc) && $stable(trap_cause) && $stable(halted)));

  a_r10_one_reason: assert property (@(posedge clk) disable iff (!rst_n)
    !(halted && trap_cause != 2'd0));

  a_r12_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !instr_valid |=> $stable(pc));

  a_r9_pc_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    pc[1:0] == 2'b00);
endmodule

bind nextpc_unit nextpc_unit_chk i_chk (
  .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .rd_idx(rd_idx),
  .pc(pc), .link_we(link_we), .trap_cause(trap_cause), .halted(halted)
);

// File: tb/test_nextpc_unit.sv
module test_nextpc_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        instr_valid = 1'b0;
  logic [3:0]  op = 4'd0;
  logic [4:0]  rd_idx = 5'd0;
  logic [31:0] rs1_val = '0, rs2_val = '0, imm = '0;
  logic [31:0] pc, next_pc, link_data;
  logic        link_we, halted;
  logic [1:0]  trap_cause;
  int checks = 0;
  int fails = 0;

  always #4 clk = ~clk;

  nextpc_unit i_nextpc_unit (
    .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .op(op), .rd_idx(rd_idx),
    .rs1_val(rs1_val), .rs2_val(rs2_val), .imm(imm), .pc(pc), .next_pc(next_pc),
    .link_we(link_we), .link_data(link_data), .trap_cause(trap_cause), .halted(halted)
  );

  // {op, rs1, rs2, imm, rd, exp_next_pc, exp_we, exp_cause, exp_halt}, starting from pc 0x100
  localparam int NV = 20;
  localparam logic [140:0] VEC [NV] = '{
    {4'd0,  32'h0,        32'h0, 32'h0,        5'd3, 32'h104, 1'b0, 2'd0, 1'b0}, // R2
    {4'd1,  32'h0,        32'h0, 32'h20,       5'd1, 32'h120, 1'b1, 2'd0, 1'b0}, // R3
    {4'd1,  32'h0,        32'h0, 32'hFFFFFFF8, 5'd0, 32'h0F8, 1'b0, 2'd0, 1'b0}, // R5
    {4'd2,  32'h203,      32'h0, 32'h1,        5'd5, 32'h204, 1'b1, 2'd0, 1'b0}, // R4
    {4'd2,  32'h301,      32'h0, 32'h0,        5'd7, 32'h300, 1'b1, 2'd0, 1'b0}, // R4 bit0 cleared
    {4'd2,  32'h202,      32'h0, 32'h0,        5'd7, 32'h100, 1'b0, 2'd1, 1'b0}, // R8
    {4'd1,  32'h0,        32'h0, 32'h6,        5'd1, 32'h100, 1'b0, 2'd1, 1'b0}, // R8
    {4'd8,  32'h5,        32'h5, 32'h40,       5'd0, 32'h140, 1'b0, 2'd0, 1'b0}, // R6
    {4'd8,  32'h5,        32'h6, 32'h40,       5'd0, 32'h104, 1'b0, 2'd0, 1'b0}, // R6
    {4'd9,  32'h5,        32'h6, 32'hFFFFFFF0, 5'd0, 32'h0F0, 1'b0, 2'd0, 1'b0}, // R6
    {4'd12, 32'hFFFFFFFF, 32'h1, 32'h10,       5'd0, 32'h110, 1'b0, 2'd0, 1'b0}, // R6
    {4'd14, 32'hFFFFFFFF, 32'h1, 32'h10,       5'd0, 32'h104, 1'b0, 2'd0, 1'b0}, // R7
    {4'd13, 32'hFFFFFFFF, 32'h1, 32'h10,       5'd0, 32'h104, 1'b0, 2'd0, 1'b0}, // R6
    {4'd15, 32'hFFFFFFFF, 32'h1, 32'h8,        5'd0, 32'h108, 1'b0, 2'd0, 1'b0}, // R7
    {4'd8,  32'h1,        32'h2, 32'h2,        5'd0, 32'h100, 1'b0, 2'd2, 1'b0}, // R9
    {4'd9,  32'h1,        32'h1, 32'h0,        5'd0, 32'h100, 1'b0, 2'd0, 1'b1}, // R10
    {4'd1,  32'h0,        32'h0, 32'h0,        5'd1, 32'h100, 1'b0, 2'd0, 1'b1}, // R10
    {4'd2,  32'h101,      32'h0, 32'hFFFFFFFF, 5'd1, 32'h100, 1'b0, 2'd0, 1'b1}, // R10
    {4'd10, 32'h0,        32'h0, 32'h40,       5'd2, 32'h104, 1'b0, 2'd0, 1'b0}, // R2
    {4'd13, 32'h3,        32'h3, 32'h20,       5'd0, 32'h120, 1'b0, 2'd0, 1'b0}  // R6
  };

  function automatic string tag_of(input int i);
    case (i)
      0, 18:         return "R2";
      1:             return "R3";
      2:             return "R5";
      3, 4:          return "R4";
      5, 6:          return "R8";
      11, 13:        return "R7";
      14:            return "R9";
      15, 16, 17:    return "R10";
      default:       return "R6";
    endcase
  endfunction

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    instr_valid = 1'b0;
    @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic present(input logic [3:0] o, input logic [31:0] a, input logic [31:0] b,
                         input logic [31:0] im, input logic [4:0] rd, input logic v);
    op = o; rs1_val = a; rs2_val = b; imm = im; rd_idx = rd; instr_valid = v;
    #1;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    instr_valid = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    // R1: state during and after reset
    rst_n = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check("R1", "pc in reset", pc, 32'h100);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "pc after reset", pc, 32'h100);
    check("R1", "cause after reset", {30'd0, trap_cause}, 32'd0);
    check("R1", "halted after reset", {31'd0, halted}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      do_reset();
      present(VEC[i][140:137], VEC[i][136:105], VEC[i][104:73], VEC[i][72:41], VEC[i][40:36], 1'b1);
      check(tag_of(i), "next_pc", next_pc, VEC[i][35:4]);
      check(tag_of(i), "link_we", {31'd0, link_we}, {31'd0, VEC[i][3]});
      if (VEC[i][3]) check(tag_of(i), "link_data", link_data, 32'h104);
      step();
      check(tag_of(i), "pc after edge", pc, VEC[i][35:4]);
      check(tag_of(i), "cause", {30'd0, trap_cause}, {30'd0, VEC[i][2:1]});
      check(tag_of(i), "halted", {31'd0, halted}, {31'd0, VEC[i][0]});
    end

    // R12: invalid instruction has no effect
    do_reset();
    present(4'd1, 32'h0, 32'h0, 32'h20, 5'd1, 1'b0);
    check("R12", "idle next_pc", next_pc, 32'h100);
    check("R12", "idle link_we", {31'd0, link_we}, 32'd0);
    step();
    check("R12", "idle pc", pc, 32'h100);

    // R3/R6 back-to-back without reset
    do_reset();
    present(4'd1, 32'h0, 32'h0, 32'h20, 5'd1, 1'b1);
    step();
    check("R3", "seq pc 1", pc, 32'h120);
    present(4'd8, 32'h0, 32'h0, 32'hFFFFFFE0, 5'd0, 1'b1);
    step();
    check("R6", "seq pc 2", pc, 32'h100);
    present(4'd9, 32'h0, 32'h0, 32'h8, 5'd0, 1'b1);
    step();
    check("R6", "seq pc 3", pc, 32'h104);

    // R11: trap is sticky until reset
    do_reset();
    present(4'd12, 32'h9, 32'h1, 32'hA, 5'd0, 1'b1);
    step();
    check("R11", "branch trap cause", {30'd0, trap_cause}, 32'd2);
    present(4'd1, 32'h0, 32'h0, 32'h20, 5'd1, 1'b1);
    check("R11", "frozen next_pc", next_pc, 32'h100);
    check("R11", "frozen link_we", {31'd0, link_we}, 32'd0);
    step();
    check("R11", "frozen pc", pc, 32'h100);
    check("R11", "cause held", {30'd0, trap_cause}, 32'd2);
    present(4'd0, 32'h0, 32'h0, 32'h0, 5'd0, 1'b1);
    step();
    check("R11", "non-control frozen pc", pc, 32'h100);

    // R11: halt is sticky, then cleared by reset
    do_reset();
    present(4'd1, 32'h0, 32'h0, 32'h0, 5'd4, 1'b1);
    step();
    check("R11", "halt set", {31'd0, halted}, 32'd1);
    present(4'd2, 32'h400, 32'h0, 32'h0, 5'd4, 1'b1);
    check("R11", "halted link_we", {31'd0, link_we}, 32'd0);
    step();
    check("R11", "halted pc", pc, 32'h100);
    check("R11", "halt held", {31'd0, halted}, 32'd1);
    do_reset();
    check("R1", "halt cleared", {31'd0, halted}, 32'd0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule